// File: doc/BRIEF.md
# Split-mode significand multiplier

This block is the unsigned significand multiplier of a fused multiply-add datapath. A single array of partial products feeds a reduction tree built from rows of 4-2 compressors. The mode input selects one of two uses for that array. In wide mode it forms one 106-bit product of two 53-bit significands. In split mode it forms two independent 48-bit products of 24-bit significands at the same time, because the partial-product bits that would mix the two lanes are forced to zero.

The result leaves the block as a registered carry-save pair (a sum vector and a carry vector). A downstream adder, or a reference model, adds them modulo 2^106 to get the exact result. A valid flag follows the input valid one cycle later. The output registers load only on valid input cycles. Exponents, signs, alignment and rounding are handled elsewhere.

Top module: `smul_split`

## Requirements
- R1: With i_mode = 0 (wide), the sum of o_sum and o_carry modulo 2^106 equals i_a * i_b for any two 53-bit unsigned operands.
- R2: With i_mode = 1 (split), bits 47:0 of the resolved result equal i_a[23:0] * i_b[23:0].
- R3: In split mode, bits 105:58 of the resolved result equal i_a[52:29] * i_b[52:29].
- R4: In split mode, bits 57:48 of the resolved result are zero.
- R5: In split mode, bits 28:24 of either operand have no effect on the outputs.
- R6: In split mode the lanes are isolated. Changing the upper-lane operands leaves bits 47:0 unchanged, and changing the lower-lane operands leaves bits 105:58 unchanged.
- R7: o_valid in a cycle equals i_valid in the previous cycle, and the result of an operand pair presented with i_valid high appears one clock edge later.
- R8: A synchronous active-high reset clears o_valid, o_sum and o_carry to zero.
- R9: While i_valid is low, o_sum and o_carry keep their previous values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Operands and mode are valid this cycle |
| i_mode | input | 1 | 0: one 53x53 product, 1: two 24x24 products |
| i_a | input | 53 | Multiplicand significand(s) |
| i_b | input | 53 | Multiplier significand(s) |
| o_valid | output | 1 | Registered copy of i_valid |
| o_sum | output | 106 | Carry-save sum vector |
| o_carry | output | 106 | Carry-save carry vector |

## Verification
Wide mode is tried with all-ones operands, a zero operand, a single set bit at positions 0, 23, 29 and 52, and pseudo-random values. Together these separate a wrong carry weighting in the compressor rows from a missing or misplaced partial-product row. Split mode uses the same kinds of pattern inside each lane, including bits at the lane edges (0, 23, 29, 52). It also sets the five unused middle bits and changes one lane while the other is held, which exposes any leak of cross-lane partial products into the other field or into the zero gap. Further scenarios check the valid timing, the holding of the result while valid is low, and the clearing by reset after a nonzero result.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;

    localparam int SIG_W  = 53;
    localparam int LANE_W = 24;

    typedef enum logic {
        MODE_WIDE  = 1'b0,
        MODE_SPLIT = 1'b1
    } mul_mode_e;

    // rows left after one level of 4-2 compression (missing inputs padded with zero)
    function automatic int next_rows(input int n);
        return (n > 2) ? 2 * ((n + 3) / 4) : n;
    endfunction

    function automatic int rows_at(input int n0, input int lvl);
        int n;
        n = n0;
        for (int i = 0; i < lvl; i++) n = next_rows(n);
        return n;
    endfunction

    function automatic int tree_levels(input int n0);
        int n;
        int cnt;
        n = n0;
        cnt = 0;
        while (n > 2) begin
            n = next_rows(n);
            cnt++;
        end
        return cnt;
    endfunction

    // index of the first row of a level in the flattened node array
    function automatic int level_base(input int n0, input int lvl);
        int acc;
        acc = 0;
        for (int i = 0; i < lvl; i++) acc += rows_at(n0, i);
        return acc;
    endfunction

endpackage

// File: rtl/smul_csa42_row.sv
`timescale 1ns/1ps
module smul_csa42_row #(
    parameter int W = 106
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] x3,
    output logic [W-1:0] o_s,
    output logic [W-1:0] o_c
);
    logic [W-1:0] lat_cout;
    logic [W-1:0] lat_cin;
    logic [W-1:0] part_s;
    logic [W-1:0] maj_c;

    always_comb begin
        part_s   = x0 ^ x1 ^ x2;
        lat_cout = (x0 & x1) | (x0 & x2) | (x1 & x2);
        lat_cin  = {lat_cout[W-2:0], 1'b0};
        o_s      = part_s ^ x3 ^ lat_cin;
        maj_c    = (part_s & x3) | (part_s & lat_cin) | (x3 & lat_cin);
        o_c      = {maj_c[W-2:0], 1'b0};
    end

    // each compressor row keeps the arithmetic total of its four inputs
    always_comb begin
        if (!$isunknown({x0, x1, x2, x3}))
            p_csa_sum_r1: assert (W'(o_s + o_c) == W'(x0 + x1 + x2 + x3));
    end

endmodule

// File: rtl/smul_ppgen.sv
`timescale 1ns/1ps
module smul_ppgen
    import smul_pkg::*;
#(
    parameter int SIG_W  = smul_pkg::SIG_W,
    parameter int LANE_W = smul_pkg::LANE_W,
    parameter int PROD_W = 2 * SIG_W
) (
    input  logic [SIG_W-1:0]  a,
    input  logic [SIG_W-1:0]  b,
    input  mul_mode_e         mode,
    output logic [PROD_W-1:0] pp [SIG_W]
);
    localparam logic [SIG_W-1:0] LO_M = {{(SIG_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    localparam logic [SIG_W-1:0] HI_M = {{LANE_W{1'b1}}, {(SIG_W-LANE_W){1'b0}}};

    for (genvar j = 0; j < SIG_W; j++) begin : g_row
        // in split mode a multiplier bit only sees the multiplicand bits of its own lane
        localparam logic [SIG_W-1:0] ROW_M =
            (j < LANE_W) ? LO_M : ((j >= SIG_W - LANE_W) ? HI_M : '0);
        logic [SIG_W-1:0] sel;
        assign sel   = (mode == MODE_SPLIT) ? ROW_M : '1;
        assign pp[j] = {{(PROD_W-SIG_W){1'b0}}, a & sel & {SIG_W{b[j]}}} << j;
    end

endmodule

// File: rtl/smul_tree.sv
`timescale 1ns/1ps
module smul_tree
    import smul_pkg::*;
#(
    parameter int W = 106,
    parameter int N = 53
) (
    input  logic [W-1:0] rows [N],
    output logic [W-1:0] o_sum,
    output logic [W-1:0] o_carry
);
    localparam int LEV = tree_levels(N);
    localparam int TOT = level_base(N, LEV) + rows_at(N, LEV);

    logic [W-1:0] nd [TOT];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign nd[i] = rows[i];
    end

    for (genvar l = 0; l < LEV; l++) begin : g_lvl
        localparam int NL = rows_at(N, l);
        localparam int BL = level_base(N, l);
        localparam int BN = level_base(N, l + 1);
        localparam int G  = (NL + 3) / 4;
        for (genvar g = 0; g < G; g++) begin : g_grp
            logic [W-1:0] x [4];
            for (genvar k = 0; k < 4; k++) begin : g_pick
                if (4 * g + k < NL) begin : g_live
                    assign x[k] = nd[BL + 4 * g + k];
                end else begin : g_pad
                    assign x[k] = '0;
                end
            end
            smul_csa42_row #(.W(W)) u_row (
                .x0  (x[0]),
                .x1  (x[1]),
                .x2  (x[2]),
                .x3  (x[3]),
                .o_s (nd[BN + 2 * g]),
                .o_c (nd[BN + 2 * g + 1])
            );
        end
    end

    assign o_sum   = nd[TOT - 2];
    assign o_carry = nd[TOT - 1];

endmodule

// File: rtl/smul_split.sv
`timescale 1ns/1ps
module smul_split
    import smul_pkg::*;
#(
    parameter int SIG_W  = smul_pkg::SIG_W,
    parameter int LANE_W = smul_pkg::LANE_W,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic              i_mode,
    input  logic [SIG_W-1:0]  i_a,
    input  logic [SIG_W-1:0]  i_b,
    output logic              o_valid,
    output logic [PROD_W-1:0] o_sum,
    output logic [PROD_W-1:0] o_carry
);
    localparam int GAP_LO = 2 * LANE_W;
    localparam int GAP_W  = PROD_W - 4 * LANE_W;

    mul_mode_e         mode;
    logic [PROD_W-1:0] pp [SIG_W];
    logic [PROD_W-1:0] cs_sum;
    logic [PROD_W-1:0] cs_carry;
    logic [PROD_W-1:0] resolved;

    assign mode = mul_mode_e'(i_mode);

    smul_ppgen #(.SIG_W(SIG_W), .LANE_W(LANE_W), .PROD_W(PROD_W)) u_ppgen (
        .a    (i_a),
        .b    (i_b),
        .mode (mode),
        .pp   (pp)
    );

    smul_tree #(.W(PROD_W), .N(SIG_W)) u_tree (
        .rows    (pp),
        .o_sum   (cs_sum),
        .o_carry (cs_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_sum   <= '0;
            o_carry <= '0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) begin
                o_sum   <= cs_sum;
                o_carry <= cs_carry;
            end
        end
    end

    assign resolved = o_sum + o_carry;

    p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!o_valid && o_sum == '0 && o_carry == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> ($stable(o_sum) && $stable(o_carry)));
    p_gap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_mode) |=> (resolved[GAP_LO +: GAP_W] == '0));
    p_zero_op_r1: assert property (@(posedge clk) disable iff (rst)
        (i_valid && !i_mode && (i_a == '0 || i_b == '0)) |=> (resolved == '0));

endmodule

// File: tb/test_smul_split.sv
`timescale 1ns/1ps
module test_smul_split;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         i_valid = 1'b0;
    logic         i_mode = 1'b0;
    logic [52:0]  i_a = '0;
    logic [52:0]  i_b = '0;
    logic         o_valid;
    logic [105:0] o_sum;
    logic [105:0] o_carry;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    smul_split i_smul_split (
        .clk     (clk),
        .rst     (rst),
        .i_valid (i_valid),
        .i_mode  (i_mode),
        .i_a     (i_a),
        .i_b     (i_b),
        .o_valid (o_valid),
        .o_sum   (o_sum),
        .o_carry (o_carry)
    );

    function automatic logic [105:0] resolved();
        return o_sum + o_carry;
    endfunction

    task automatic check(input string tag, input logic [105:0] got, input logic [105:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one valid cycle; returns the resolved result sampled after the loading edge
    task automatic apply(input logic [52:0] a, input logic [52:0] b, input logic m,
                         output logic [105:0] res);
        @(negedge clk);
        i_a = a; i_b = b; i_mode = m; i_valid = 1'b1;
        @(posedge clk); #5;
        res = resolved();
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    function automatic logic [52:0] pack2(input logic [23:0] hi, input logic [4:0] mid,
                                          input logic [23:0] lo);
        return {hi, mid, lo};
    endfunction

    function automatic logic [52:0] rnd53();
        return {$urandom(), $urandom()};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        check("R8 valid after reset", 106'(o_valid), 106'd0);
        check("R8 sum after reset", o_sum, '0);
        check("R8 carry after reset", o_carry, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wide_one(input logic [52:0] a, input logic [52:0] b);
        logic [105:0] r;
        apply(a, b, 1'b0, r);
        check("R1 wide product", r, {53'd0, a} * {53'd0, b});
    endtask

    task automatic t_wide();
        wide_one('1, '1);
        wide_one('0, '1);
        wide_one('1, '0);
        wide_one(53'd1, 53'd1);
        wide_one(53'd1 << 52, 53'd1 << 52);
        wide_one(53'd1 << 23, 53'd1 << 29);
        wide_one(53'd1 << 28, '1);
        for (int i = 0; i < 20; i++) wide_one(rnd53(), rnd53());
    endtask

    task automatic split_one(input logic [23:0] ah, input logic [23:0] al,
                             input logic [23:0] bh, input logic [23:0] bl);
        logic [105:0] r;
        apply(pack2(ah, 5'd0, al), pack2(bh, 5'd0, bl), 1'b1, r);
        check("R2 low lane", 106'(r[47:0]), 106'({24'd0, al} * {24'd0, bl}));
        check("R3 high lane", 106'(r[105:58]), 106'({24'd0, ah} * {24'd0, bh}));
        check("R4 gap zero", 106'(r[57:48]), 106'd0);
    endtask

    task automatic t_split();
        split_one('1, '1, '1, '1);
        split_one('0, '0, '0, '0);
        split_one('0, '1, '1, '0);
        split_one(24'h800000, 24'h000001, 24'h800000, 24'h000001);
        split_one(24'h000001, 24'h800000, 24'h000001, 24'h800000);
        split_one(24'h800000, 24'h800000, 24'h000001, 24'hFFFFFF);
        for (int i = 0; i < 20; i++)
            split_one(24'($urandom()), 24'($urandom()), 24'($urandom()), 24'($urandom()));
    endtask

    task automatic t_ignore_mid();
        logic [105:0] r0;
        logic [105:0] r1;
        apply(pack2(24'hABCDEF, 5'd0, 24'h123456), pack2(24'hFFFFFF, 5'd0, 24'h0F0F0F), 1'b1, r0);
        apply(pack2(24'hABCDEF, 5'h1F, 24'h123456), pack2(24'hFFFFFF, 5'h1F, 24'h0F0F0F), 1'b1, r1);
        check("R5 middle bits ignored", r1, r0);
        apply(pack2(24'd0, 5'h1F, 24'd0), pack2(24'hFFFFFF, 5'h1F, 24'hFFFFFF), 1'b1, r1);
        check("R5 middle bits alone give zero", r1, '0);
    endtask

    task automatic t_isolate();
        logic [105:0] r0;
        logic [105:0] r1;
        apply(pack2(24'd0, 5'd0, 24'hFFFFFF), pack2(24'd0, 5'd0, 24'hFFFFFF), 1'b1, r0);
        apply(pack2(24'hFFFFFF, 5'd0, 24'hFFFFFF), pack2(24'hFFFFFF, 5'd0, 24'hFFFFFF), 1'b1, r1);
        check("R6 low lane unchanged by high lane", 106'(r1[47:0]), 106'(r0[47:0]));
        apply(pack2(24'hFFFFFF, 5'd0, 24'd0), pack2(24'hFFFFFF, 5'd0, 24'd0), 1'b1, r0);
        check("R6 high lane unchanged by low lane", 106'(r0[105:58]), 106'(r1[105:58]));
        check("R6 low field empty", 106'(r0[57:0]), 106'd0);
    endtask

    task automatic t_valid();
        @(negedge clk);
        i_a = 53'd7; i_b = 53'd9; i_mode = 1'b0; i_valid = 1'b1;
        #5;
        check("R7 no early valid", 106'(o_valid), 106'd0);
        @(posedge clk); #5;
        check("R7 valid one cycle later", 106'(o_valid), 106'd1);
        check("R7 result one cycle later", resolved(), 106'd63);
        @(negedge clk);
        i_valid = 1'b0;
        @(posedge clk); #5;
        check("R7 valid drops", 106'(o_valid), 106'd0);
    endtask

    task automatic t_hold();
        logic [105:0] r;
        apply(53'd1000, 53'd3000, 1'b0, r);
        check("R1 setup for hold", r, 106'd3000000);
        @(negedge clk);
        i_a = '1; i_b = '1; i_mode = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        check("R9 result held while idle", resolved(), 106'd3000000);
    endtask

    task automatic t_reset_after_data();
        logic [105:0] r;
        apply('1, '1, 1'b0, r);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #5;
        check("R8 reset clears sum", o_sum, '0);
        check("R8 reset clears carry", o_carry, '0);
        check("R8 reset clears valid", 106'(o_valid), 106'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_valid();
        t_wide();
        t_split();
        t_ignore_mid();
        t_isolate();
        t_hold();
        t_reset_after_data();
        done = 1'b1;
        finish_run();
    end

endmodule